// File: doc/BRIEF.md
# Table-driven Huffman tree walker

This block decodes the variable-length symbols of a baseline JPEG entropy-coded stream one bit at a time. The decode trees are held in four small loadable tables: two for DC coefficients and two for AC coefficients. Each stored word is either an internal node or a leaf, and its least significant bit says which. For a node, the upper bits of the word form a pointer. The next table address is that pointer with the next stream bit appended as the new least significant bit. For a leaf, the upper bits of the word are the decoded symbol.

A host first loads the tables through a write port. The port selects one table by a 2-bit id and then advances its write address by one on each write. To decode, the host starts a block and names the table set to use for it. The walker then pulls stream bits through a valid/ready handshake, one tree level per clock. For the first symbol of the block it returns a DC size category. After that it returns AC run/size bytes until end-of-block, or until the coefficient index reaches the last position.

The walker tracks the coefficient index within the block and recognises the end-of-block and sixteen-zero escape symbols. A code that is too long, or a symbol that would push the index past the end of the block, aborts the block and raises a sticky error flag.

Top module: `huff_tree_walker`

## Requirements
- R1: Asserting `tbl_sel_vld_i` makes `tbl_sel_i` the current table and resets its write address to 0. Table ids are: 0 = DC set 0, 1 = DC set 1, 2 = AC set 0, 3 = AC set 1. Each `tbl_wr_i` pulse stores `tbl_wdata_i` at the current address and then adds one to the address. DC tables keep bits [4:0] of the data and ignore bits [8:5]. AC tables keep all 9 bits.
- R2: Each bit accepted (`bit_vld_i` and `bit_rdy_o` both high at a clock edge) reads the table word at address {pointer, bit}. If bit 0 of the word is 0, the word is a node, and the word shifted right by one becomes the new pointer. If bit 0 is 1, the word is a leaf, and the word shifted right by one is the symbol.
- R3: `blk_start_i` is taken only while `blk_busy_o` is low, and `blk_set_i` picks the table set for the whole block. The first symbol of a block is read from that set's DC table and is presented with `sym_ac_o`=0, as a 4-bit category zero-extended on `sym_o`. Every later symbol of the block is read from the AC table of the same set and is presented with `sym_ac_o`=1.
- R4: The pointer and the code-length count return to zero at the start of every symbol, so each symbol is decoded from the tree root.
- R5: A cycle with `bit_vld_i` low consumes no bit and changes no decoding state, whatever value `bit_i` holds.
- R6: While `sym_vld_o` is high and `sym_rdy_i` is low, `sym_o` and its flags stay stable and `bit_rdy_o` stays low.
- R7: The AC symbol 0x00 is presented with `sym_eob_o`=1. Once it is accepted, the block ends and `blk_busy_o` goes low.
- R8: The AC symbol 0xF0 is presented with `sym_zrl_o`=1. It advances the coefficient index by 16, and decoding of the block continues.
- R9: The index starts at 0 after the DC symbol. Every other AC symbol advances it by its upper nibble plus one. When a symbol brings the index to exactly 63, the block ends once that symbol is accepted, with no end-of-block symbol needed.
- R10: An AC leaf that would bring the index above 63 is not presented. Instead, `err_o` rises and the block ends in the same clock.
- R11: Codes of up to 16 bits decode normally. If the 16th bit of a code still reaches a node, `err_o` rises and the block ends in the same clock.
- R12: After reset, `blk_busy_o`, `bit_rdy_o`, `sym_vld_o` and `err_o` are all low. `err_o` stays high until the next accepted `blk_start_i` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_sel_i | input | 2 | Table id to select |
| tbl_sel_vld_i | input | 1 | Select the table and reset its write address |
| tbl_wr_i | input | 1 | Write strobe for the current table |
| tbl_wdata_i | input | 9 | Table word to write |
| blk_start_i | input | 1 | Start decoding a block |
| blk_set_i | input | 1 | Table set used for the block |
| blk_busy_o | output | 1 | A block is being decoded |
| bit_i | input | 1 | Stream bit |
| bit_vld_i | input | 1 | Stream bit valid |
| bit_rdy_o | output | 1 | Walker can take a stream bit |
| sym_o | output | 8 | Decoded symbol |
| sym_ac_o | output | 1 | Symbol came from an AC table |
| sym_eob_o | output | 1 | Symbol is end-of-block |
| sym_zrl_o | output | 1 | Symbol is the sixteen-zero escape |
| sym_vld_o | output | 1 | Symbol valid |
| sym_rdy_i | input | 1 | Symbol accepted |
| err_o | output | 1 | Sticky decode error |

## Verification
The leaf that completes an AC code and the check on the coefficient index act in the same clock. That clock decides whether a symbol appears or the error flag rises. The bench provokes this with run sums that land exactly on 63 and just past it. In the first case it expects the symbol followed by the end of the block with `err_o` low. In the second it expects no symbol, `err_o` high and `blk_busy_o` low at the next sample. The last-bit edge of a 16-bit code is judged the same way: a 16-bit code ending on a leaf must decode, while sixteen bits that still end on a node must raise the error.

// File: rtl/huff_walk_pkg.sv
package huff_walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_EMIT
  } walk_st_e;

  localparam int unsigned NUM_TBL = 4;
  localparam int unsigned TBL_ID_W = 2;
endpackage

// File: rtl/huff_tbl_bank.sv
module huff_tbl_bank #(
  parameter int unsigned WW = 5,
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [WW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [WW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [WW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // combinational read keeps one tree level per clock
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/huff_tbl_wr.sv
module huff_tbl_wr import huff_walk_pkg::*; #(
  parameter int unsigned AW = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TBL_ID_W-1:0] sel_i,
  input  logic                sel_vld_i,
  input  logic                wr_i,
  output logic [TBL_ID_W-1:0] id_o,
  output logic [AW-1:0]       addr_o,
  output logic                we_o
);
  logic [TBL_ID_W-1:0] id_q;
  logic [AW-1:0]       addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      addr_q <= '0;
    end else if (sel_vld_i) begin
      id_q   <= sel_i;
      addr_q <= '0;
    end else if (wr_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign id_o   = id_q;
  assign addr_o = addr_q;
  assign we_o   = wr_i && !sel_vld_i;
endmodule

// File: rtl/huff_walk_core.sv
module huff_walk_core import huff_walk_pkg::*; #(
  parameter int unsigned AC_PTR_W     = 8,
  parameter int unsigned MAX_CODE_LEN = 16,
  parameter int unsigned BLK_COEF     = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  blk_start_i,
  input  logic                  blk_set_i,
  output logic                  busy_o,
  input  logic                  bit_i,
  input  logic                  bit_vld_i,
  output logic                  bit_rdy_o,
  output logic [TBL_ID_W-1:0]   rd_id_o,
  output logic [AC_PTR_W:0]     rd_addr_o,
  input  logic [AC_PTR_W:0]     rd_word_i,
  output logic [AC_PTR_W-1:0]   sym_o,
  output logic                  sym_ac_o,
  output logic                  sym_eob_o,
  output logic                  sym_zrl_o,
  output logic                  sym_vld_o,
  input  logic                  sym_rdy_i,
  output logic                  err_o
);
  localparam int unsigned SW   = AC_PTR_W;
  localparam int unsigned RW   = SW / 2;
  localparam int unsigned IW   = $clog2(BLK_COEF);
  localparam int unsigned DW   = $clog2(MAX_CODE_LEN + 1);
  localparam int unsigned LAST = BLK_COEF - 1;
  localparam logic [SW-1:0] ZRL_SYM = {{RW{1'b1}}, {(SW-RW){1'b0}}};

  walk_st_e      state_q;
  logic [SW-1:0] ptr_q, sym_q;
  logic [DW-1:0] depth_q;
  logic [IW-1:0] cidx_q;
  logic          is_ac_q, set_q, err_q;

  logic          leaf, ac_eob, ovr, too_long;
  logic [SW-1:0] nxt;
  logic [RW-1:0] run;
  logic [IW:0]   sum;

  assign leaf     = rd_word_i[0];
  assign nxt      = rd_word_i[SW:1];
  assign run      = nxt[SW-1:SW-RW];
  assign sum      = {1'b0, cidx_q} + (IW+1)'(run) + (IW+1)'(1);
  assign ac_eob   = (nxt == '0);
  assign ovr      = is_ac_q && !ac_eob && (sum > (IW+1)'(LAST));
  assign too_long = (depth_q == DW'(MAX_CODE_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      sym_q   <= '0;
      depth_q <= '0;
      cidx_q  <= '0;
      is_ac_q <= 1'b0;
      set_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (blk_start_i) begin
          state_q <= ST_WALK;
          set_q   <= blk_set_i;
          is_ac_q <= 1'b0;
          ptr_q   <= '0;
          depth_q <= '0;
          cidx_q  <= '0;
          err_q   <= 1'b0;
        end
        ST_WALK: if (bit_vld_i) begin
          if (leaf) begin
            if (ovr) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              sym_q   <= nxt;
              state_q <= ST_EMIT;
              if (is_ac_q && !ac_eob) cidx_q <= sum[IW-1:0];
            end
          end else if (too_long) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ptr_q   <= nxt;
            depth_q <= depth_q + 1'b1;
          end
        end
        ST_EMIT: if (sym_rdy_i) begin
          ptr_q   <= '0;
          depth_q <= '0;
          if (!is_ac_q) begin
            is_ac_q <= 1'b1;
            state_q <= ST_WALK;
          end else if (sym_q == '0 || cidx_q == IW'(LAST)) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WALK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o = {ptr_q, bit_i};
  assign rd_id_o   = {is_ac_q, set_q};
  assign bit_rdy_o = (state_q == ST_WALK);
  assign sym_vld_o = (state_q == ST_EMIT);
  assign busy_o    = (state_q != ST_IDLE);
  assign sym_o     = sym_q;
  assign sym_ac_o  = is_ac_q;
  assign sym_eob_o = is_ac_q && (sym_q == '0);
  assign sym_zrl_o = is_ac_q && (sym_q == ZRL_SYM);
  assign err_o     = err_q;
endmodule

// File: rtl/huff_tree_walker.sv
module huff_tree_walker import huff_walk_pkg::*; #(
  parameter int unsigned DC_PTR_W     = 4,
  parameter int unsigned AC_PTR_W     = 8,
  parameter int unsigned MAX_CODE_LEN = 16,
  parameter int unsigned BLK_COEF     = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          tbl_sel_i,
  input  logic                tbl_sel_vld_i,
  input  logic                tbl_wr_i,
  input  logic [AC_PTR_W:0]   tbl_wdata_i,
  input  logic                blk_start_i,
  input  logic                blk_set_i,
  output logic                blk_busy_o,
  input  logic                bit_i,
  input  logic                bit_vld_i,
  output logic                bit_rdy_o,
  output logic [AC_PTR_W-1:0] sym_o,
  output logic                sym_ac_o,
  output logic                sym_eob_o,
  output logic                sym_zrl_o,
  output logic                sym_vld_o,
  input  logic                sym_rdy_i,
  output logic                err_o
);
  localparam int unsigned DC_WW = DC_PTR_W + 1;
  localparam int unsigned DC_AW = DC_PTR_W + 1;
  localparam int unsigned AC_WW = AC_PTR_W + 1;
  localparam int unsigned AC_AW = AC_PTR_W + 1;

  logic [TBL_ID_W-1:0] wr_id, rd_id;
  logic [AC_AW-1:0]    wr_addr, rd_addr;
  logic                wr_en;
  logic [AC_WW-1:0]    rd_words [NUM_TBL];

  huff_tbl_wr #(.AW(AC_AW)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (tbl_sel_i),
    .sel_vld_i (tbl_sel_vld_i),
    .wr_i      (tbl_wr_i),
    .id_o      (wr_id),
    .addr_o    (wr_addr),
    .we_o      (wr_en)
  );

  // id bit 1 picks AC over DC, id bit 0 picks the set
  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    logic bank_we;
    assign bank_we = wr_en && (wr_id == TBL_ID_W'(g));
    if (g < 2) begin : g_dc
      logic [DC_WW-1:0] dc_word;
      huff_tbl_bank #(.WW(DC_WW), .AW(DC_AW)) u_bank (
        .clk_i   (clk_i),
        .we_i    (bank_we),
        .waddr_i (wr_addr[DC_AW-1:0]),
        .wdata_i (tbl_wdata_i[DC_WW-1:0]),
        .raddr_i (rd_addr[DC_AW-1:0]),
        .rdata_o (dc_word)
      );
      assign rd_words[g] = {{(AC_WW-DC_WW){1'b0}}, dc_word};
    end else begin : g_ac
      huff_tbl_bank #(.WW(AC_WW), .AW(AC_AW)) u_bank (
        .clk_i   (clk_i),
        .we_i    (bank_we),
        .waddr_i (wr_addr),
        .wdata_i (tbl_wdata_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_words[g])
      );
    end
  end

  huff_walk_core #(
    .AC_PTR_W     (AC_PTR_W),
    .MAX_CODE_LEN (MAX_CODE_LEN),
    .BLK_COEF     (BLK_COEF)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blk_start_i (blk_start_i),
    .blk_set_i   (blk_set_i),
    .busy_o      (blk_busy_o),
    .bit_i       (bit_i),
    .bit_vld_i   (bit_vld_i),
    .bit_rdy_o   (bit_rdy_o),
    .rd_id_o     (rd_id),
    .rd_addr_o   (rd_addr),
    .rd_word_i   (rd_words[rd_id]),
    .sym_o       (sym_o),
    .sym_ac_o    (sym_ac_o),
    .sym_eob_o   (sym_eob_o),
    .sym_zrl_o   (sym_zrl_o),
    .sym_vld_o   (sym_vld_o),
    .sym_rdy_i   (sym_rdy_i),
    .err_o       (err_o)
  );
endmodule

// File: rtl/huff_tree_walker_chk.sv
module huff_tree_walker_chk #(
  parameter int unsigned SW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          blk_start_i,
  input logic          blk_busy_o,
  input logic          bit_rdy_o,
  input logic [SW-1:0] sym_o,
  input logic          sym_ac_o,
  input logic          sym_eob_o,
  input logic          sym_zrl_o,
  input logic          sym_vld_o,
  input logic          sym_rdy_i,
  input logic          err_o
);
  p_no_bit_while_sym_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> !bit_rdy_o);

  p_sym_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o && !sym_rdy_i |=> sym_vld_o && $stable(sym_o) && $stable(sym_ac_o));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_busy_o |-> !bit_rdy_o && !sym_vld_o);

  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !blk_start_i |=> err_o);

  p_err_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !blk_busy_o && !sym_vld_o);

  p_eob_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o && sym_rdy_i && sym_eob_o |=> !blk_busy_o);

  p_dc_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_busy_o) |-> !sym_ac_o);

  p_dc_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o && !sym_ac_o |-> sym_o[SW-1:4] == '0);

  p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> !(sym_eob_o && sym_zrl_o));
endmodule

bind huff_tree_walker huff_tree_walker_chk #(.SW(AC_PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blk_start_i (blk_start_i),
  .blk_busy_o  (blk_busy_o),
  .bit_rdy_o   (bit_rdy_o),
  .sym_o       (sym_o),
  .sym_ac_o    (sym_ac_o),
  .sym_eob_o   (sym_eob_o),
  .sym_zrl_o   (sym_zrl_o),
  .sym_vld_o   (sym_vld_o),
  .sym_rdy_i   (sym_rdy_i),
  .err_o       (err_o)
);

// File: tb/huff_tree_walker_bench.sv
module huff_tree_walker_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] tbl_sel_i = '0;
  logic       tbl_sel_vld_i = 1'b0;
  logic       tbl_wr_i = 1'b0;
  logic [8:0] tbl_wdata_i = '0;
  logic       blk_start_i = 1'b0;
  logic       blk_set_i = 1'b0;
  logic       blk_busy_o;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       bit_rdy_o;
  logic [7:0] sym_o;
  logic       sym_ac_o, sym_eob_o, sym_zrl_o, sym_vld_o;
  logic       sym_rdy_i = 1'b0;
  logic       err_o;

  int n_chk = 0;
  int n_fail = 0;
  int gap_ctr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  huff_tree_walker u_huff_tree_walker (
    .clk_i(clk), .rst_ni(rst_ni),
    .tbl_sel_i(tbl_sel_i), .tbl_sel_vld_i(tbl_sel_vld_i),
    .tbl_wr_i(tbl_wr_i), .tbl_wdata_i(tbl_wdata_i),
    .blk_start_i(blk_start_i), .blk_set_i(blk_set_i), .blk_busy_o(blk_busy_o),
    .bit_i(bit_i), .bit_vld_i(bit_vld_i), .bit_rdy_o(bit_rdy_o),
    .sym_o(sym_o), .sym_ac_o(sym_ac_o), .sym_eob_o(sym_eob_o),
    .sym_zrl_o(sym_zrl_o), .sym_vld_o(sym_vld_o), .sym_rdy_i(sym_rdy_i),
    .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // set 0: category p is p ones then a zero; set 1 inverts every bit
  function automatic logic [8:0] dc_word(input int set, input int a);
    int p = a >> 1;
    int nx = (p < 15) ? p + 1 : 15;
    bit is_leaf = ((a & 1) == set);
    return is_leaf ? 9'((p << 1) | 1) : 9'(nx << 1);
  endfunction

  // full depth-8 tree in heap order; set 0 leaf = code, set 1 leaf = ~code
  function automatic logic [8:0] ac_word(input int set, input int a);
    int h = a + 1;
    int v;
    if (h < 255) return 9'(h << 1);
    v = h - 255;
    if (set == 1) v = (~v) & 255;
    return 9'((v << 1) | 1);
  endfunction

  task automatic sel_tbl(input int id);
    tbl_sel_i = 2'(id);
    tbl_sel_vld_i = 1'b1;
    @(negedge clk);
    tbl_sel_vld_i = 1'b0;
  endtask

  task automatic wr_word(input logic [8:0] d);
    tbl_wdata_i = d;
    tbl_wr_i = 1'b1;
    @(negedge clk);
    tbl_wr_i = 1'b0;
  endtask

  task automatic feed_bit(input logic b);
    while (!bit_rdy_o) @(negedge clk);
    bit_vld_i = 1'b1;
    bit_i = b;
    @(negedge clk);
    bit_vld_i = 1'b0;
    gap_ctr++;
    if (gap_ctr % 3 == 0) begin
      bit_i = ~b;  // R5: ignored while not valid
      @(negedge clk);
    end
  endtask

  task automatic send_dc(input int set, input int cat);
    for (int i = 0; i <= cat; i++) feed_bit(((i < cat) ? 1'b1 : 1'b0) ^ set[0]);
  endtask

  task automatic send_ac(input int set, input logic [7:0] v);
    logic [7:0] code = (set == 1) ? ~v : v;
    for (int i = 7; i >= 0; i--) feed_bit(code[i]);
  endtask

  task automatic take_sym(input logic [7:0] exp, input logic ac, input bit hold,
                          input string tag);
    logic [10:0] e, a;
    logic [7:0] saved;
    while (!sym_vld_o) @(negedge clk);
    e = {ac, ac && exp == 8'h00, ac && exp == 8'hF0, exp};
    a = {sym_ac_o, sym_eob_o, sym_zrl_o, sym_o};
    chk(a == e, tag, 32'(a), 32'(e));
    if (hold) begin
      saved = sym_o;
      repeat (2) @(negedge clk);
      chk(sym_vld_o && sym_o == saved && !bit_rdy_o, "R6 hold",
          {sym_vld_o, bit_rdy_o, sym_o}, {2'b10, saved});
    end
    sym_rdy_i = 1'b1;
    @(negedge clk);
    sym_rdy_i = 1'b0;
  endtask

  task automatic start_blk(input int set);
    blk_set_i = set[0];
    blk_start_i = 1'b1;
    @(negedge clk);
    blk_start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({blk_busy_o, bit_rdy_o, sym_vld_o, err_o} == 4'b0, "R12 reset",
        {blk_busy_o, bit_rdy_o, sym_vld_o, err_o}, 0);

    // R1: partial garbage load, then reselect restarts at address 0
    sel_tbl(0);
    for (int a = 0; a < 3; a++) wr_word(9'h1FF);
    for (int t = 0; t < 2; t++) begin
      sel_tbl(t);
      for (int a = 0; a < 32; a++) wr_word({4'b1010, dc_word(t, a)[4:0]});
    end
    for (int t = 0; t < 2; t++) begin
      sel_tbl(2 + t);
      for (int a = 0; a < 510; a++) wr_word(ac_word(t, a));
    end

    // DC sweep, both sets, every category up to a 16-bit code
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        start_blk(s);
        chk(blk_busy_o && !err_o, "R3 start", {blk_busy_o, err_o}, 2'b10);
        send_dc(s, c);
        take_sym(8'(c), 1'b0, (c % 4) == 0, "R1 R3 R11 dc");
        send_ac(s, 8'h00);
        take_sym(8'h00, 1'b1, 1'b0, "R7 eob");
        chk(!blk_busy_o, "R7 end", blk_busy_o, 0);
      end
    end

    // AC sweep over all run/size bytes
    for (int v = 1; v < 256; v++) begin
      if (v != 8'hF0) begin
        start_blk(v & 1);
        send_dc(v & 1, v % 12);
        take_sym(8'(v % 12), 1'b0, 1'b0, "R3 dc");
        send_ac(v & 1, 8'(v));
        take_sym(8'(v), 1'b1, (v % 8) == 0, "R2 R4 R5 ac");
        chk(blk_busy_o, "R9 continues", blk_busy_o, 1);
        send_ac(v & 1, 8'h00);
        take_sym(8'h00, 1'b1, 1'b0, "R7 eob");
        chk(!blk_busy_o && !err_o, "R7 end", {blk_busy_o, err_o}, 0);
      end
    end

    // index lands exactly on 63: 16+16+16+15
    start_blk(0);
    send_dc(0, 5);
    take_sym(8'd5, 1'b0, 1'b0, "R3 dc");
    for (int k = 0; k < 3; k++) begin
      send_ac(0, 8'hF0);
      take_sym(8'hF0, 1'b1, 1'b0, "R8 zrl");
      chk(blk_busy_o, "R8 continues", blk_busy_o, 1);
    end
    send_ac(0, 8'hE1);
    take_sym(8'hE1, 1'b1, 1'b0, "R9 last");
    chk(!blk_busy_o && !err_o, "R9 end at 63", {blk_busy_o, err_o}, 0);

    // index would reach 64
    start_blk(1);
    send_dc(1, 3);
    take_sym(8'd3, 1'b0, 1'b0, "R3 dc");
    for (int k = 0; k < 3; k++) begin
      send_ac(1, 8'hF0);
      take_sym(8'hF0, 1'b1, 1'b0, "R8 zrl");
    end
    send_ac(1, 8'hF1);
    chk(err_o && !sym_vld_o && !blk_busy_o, "R10 overrun",
        {err_o, sym_vld_o, blk_busy_o}, 3'b100);

    // R11: sixteen ones still on a node in DC set 0
    start_blk(0);
    chk(!err_o, "R12 cleared by start", err_o, 0);
    for (int k = 0; k < 15; k++) feed_bit(1'b1);
    chk(blk_busy_o && !err_o, "R11 15 bits", {blk_busy_o, err_o}, 2'b10);
    feed_bit(1'b1);
    chk(err_o && !blk_busy_o, "R11 overlength", {err_o, blk_busy_o}, 2'b10);
    repeat (4) @(negedge clk);
    chk(err_o, "R12 sticky", err_o, 1);
    start_blk(0);
    chk(!err_o && blk_busy_o, "R12 clear", {err_o, blk_busy_o}, 2'b01);
    send_dc(0, 0);
    take_sym(8'd0, 1'b0, 1'b0, "R4 after error");
    send_ac(0, 8'h00);
    take_sym(8'h00, 1'b1, 1'b0, "R7 eob");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule